// File: doc/BRIEF.md
# Bitwise-Configurable Eight-Bit I/O Port

This block is an eight-bit general-purpose I/O port. Each pin has its own direction bit, so inputs and outputs can be mixed freely inside the byte. A small synchronous register bus reaches three registers:

- a data register that holds the output latch;
- a direction register;
- a pull-up enable register.

On the pin side the block takes the raw pin levels. It drives out the output value, the per-pin output enable and the per-pin pull-up request. The pad and the resistor lie outside the block.

A read of the data register returns a different source for each bit, chosen by that bit's direction. An input bit returns the pin level, after a two-flop synchronizer. An output bit returns the value held in the output latch.

The register bus is a control path. Every access completes in one cycle and there is no back-pressure, so it uses plain address, write-strobe and data signals. It has no valid/ready handshake. Read data is combinational from the address and the current state.

Top module: `gpio_octet`

## Requirements
- R1: While reset is asserted and after it is released, the direction register is 0xFF (every bit an input, `pin_oe` = 0x00), the output latch is 0x00 (`pin_out` = 0x00) and the pull-up register is 0x00.
- R2: Address 1 is the direction register. A direction bit of 1 makes the pin an input and 0 makes it an output. `pin_oe[i]` is the inverse of direction bit i. A write updates it at the next rising clock edge, and a read returns it.
- R3: Address 0 is the data register. A write loads the output latch at the next rising clock edge, and `pin_out` always shows the latch, whatever the direction.
- R4: A read of address 0 returns, for every input bit, the `pin_in` level after two rising clock edges. After only one edge the previous level is still returned.
- R5: A read of address 0 returns, for every output bit, the output latch bit, whatever the level on `pin_in`.
- R6: Address 2 is the pull-up register. A write updates it at the next rising clock edge, `pin_pull` mirrors it, and a read returns it.
- R7: Address 3 reads as 0x00, and a write to it changes none of the three registers.
- R8: While `bus_wr` is 0, nothing on the bus changes any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 data, 1 direction, 2 pull-up, 3 unused |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pin_in | input | 8 | Raw pin levels |
| pin_out | output | 8 | Output latch value toward the pads |
| pin_oe | output | 8 | Per-pin output enable, 1 = drive |
| pin_pull | output | 8 | Per-pin pull-up enable |

## Verification
The bench targets the following corner cases:

- **Bits of one read taking different sources.** Direction patterns split the byte, and the pin is set opposite to the latch. A mux that is inverted or chosen for the whole byte then returns the wrong bits.
- **Synchronizer latency.** The pin level is read after one edge and again after two. A design with no synchronizer, or one with the wrong depth, shows the new level too early or too late.
- **Writes that must not land.** Writes to the unused address, and bus activity with the write strobe low, must leave all three registers unchanged. The bench checks this at the output pins and by reading the registers back. A loose address decode would corrupt the latch, the direction or the pull-ups.

// File: rtl/gpio_octet_pkg.sv
package gpio_octet_pkg;
  localparam int PORT_W = 8;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_DATA = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_PULL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_octet_sync.sv
module gpio_octet_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q[s] <= '0;
        end else if (s == 0) begin
          chain_q[s] <= async_i;
        end else begin
          chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_octet_regs.sv
module gpio_octet_regs
  import gpio_octet_pkg::*;
#(
  parameter int WIDTH = PORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  latch_o,
  output logic [WIDTH-1:0]  dir_o,
  output logic [WIDTH-1:0]  pull_o
);
  logic hit_data, hit_dir, hit_pull;

  always_comb begin
    hit_data = wr_i && (reg_sel_e'(addr_i) == SEL_DATA);
    hit_dir  = wr_i && (reg_sel_e'(addr_i) == SEL_DIR);
    hit_pull = wr_i && (reg_sel_e'(addr_i) == SEL_PULL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_o <= '0;
      dir_o   <= '1;
      pull_o  <= '0;
    end else begin
      if (hit_data) latch_o <= wdata_i;
      if (hit_dir)  dir_o   <= wdata_i;
      if (hit_pull) pull_o  <= wdata_i;
    end
  end
endmodule

// File: rtl/gpio_octet_rdmux.sv
module gpio_octet_rdmux
  import gpio_octet_pkg::*;
#(
  parameter int WIDTH = PORT_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  latch_i,
  input  logic [WIDTH-1:0]  dir_i,
  input  logic [WIDTH-1:0]  pull_i,
  input  logic [WIDTH-1:0]  pin_sync_i,
  output logic [WIDTH-1:0]  rdata_o
);
  logic [WIDTH-1:0] port_view;

  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      assign port_view[b] = dir_i[b] ? pin_sync_i[b] : latch_i[b];
    end
  endgenerate

  always_comb begin
    unique case (reg_sel_e'(addr_i))
      SEL_DATA: rdata_o = port_view;
      SEL_DIR:  rdata_o = dir_i;
      SEL_PULL: rdata_o = pull_i;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_octet.sv
module gpio_octet
  import gpio_octet_pkg::*;
#(
  parameter int WIDTH     = PORT_W,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe,
  output logic [WIDTH-1:0]  pin_pull
);
  logic [WIDTH-1:0] latch_q, dir_q, pull_q, pin_sync;

  gpio_octet_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr_i(bus_addr), .wr_i(bus_wr),
    .wdata_i(bus_wdata), .latch_o(latch_q), .dir_o(dir_q), .pull_o(pull_q)
  );

  gpio_octet_sync #(.WIDTH(WIDTH), .STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(pin_in), .sync_o(pin_sync)
  );

  gpio_octet_rdmux #(.WIDTH(WIDTH)) u_rdmux (
    .addr_i(bus_addr), .latch_i(latch_q), .dir_i(dir_q), .pull_i(pull_q),
    .pin_sync_i(pin_sync), .rdata_o(bus_rdata)
  );

  assign pin_out  = latch_q;
  assign pin_oe   = ~dir_q;
  assign pin_pull = pull_q;
endmodule

// File: rtl/gpio_octet_chk.sv
module gpio_octet_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       bus_addr,
  input logic             bus_wr,
  input logic [WIDTH-1:0] bus_wdata,
  input logic [WIDTH-1:0] bus_rdata,
  input logic [WIDTH-1:0] pin_out,
  input logic [WIDTH-1:0] pin_oe,
  input logic [WIDTH-1:0] pin_pull
);
  assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd1) |=> (pin_oe == ~$past(bus_wdata)));

  assert_data_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0) |=> (pin_out == $past(bus_wdata)));

  assert_out_bits_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd0) |-> (((bus_rdata ^ pin_out) & pin_oe) == '0));

  assert_pull_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd2) |=> (pin_pull == $past(bus_wdata)));

  assert_unused_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd3) |-> (bus_rdata == '0));

  assert_latch_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == 2'd0) |=> $stable(pin_out));

  assert_dir_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == 2'd1) |=> $stable(pin_oe));
endmodule

bind gpio_octet gpio_octet_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out),
  .pin_oe(pin_oe), .pin_pull(pin_pull)
);

// File: tb/gpio_octet_bench.sv
module gpio_octet_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in = '0;
  logic [7:0] pin_out, pin_oe, pin_pull;

  int total = 0;
  int bad = 0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb_q[$];

  logic [7:0] m_lat, m_dir, m_pull;

  always #4 clk = ~clk;

  gpio_octet u_gpio_octet (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_pull(pin_pull)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read items and compares them mid-cycle
  always @(negedge clk) begin
    #2;
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      check(it.tag, bus_rdata, it.exp);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    if (a == 2'd0) m_lat = d;
    if (a == 2'd1) m_dir = d;
    if (a == 2'd2) m_pull = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    @(posedge clk);
  endtask

  task automatic check_pins(input string tag);
    @(negedge clk); #2;
    check({tag, " pin_out"}, pin_out, m_lat);
    check({tag, " pin_oe"}, pin_oe, ~m_dir);
    check({tag, " pin_pull"}, pin_pull, m_pull);
  endtask

  function automatic logic [7:0] port_exp(input logic [7:0] pins);
    return (pins & m_dir) | (m_lat & ~m_dir);
  endfunction

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_lat = 8'h00; m_dir = 8'hFF; m_pull = 8'h00;
    repeat (2) @(negedge clk);
    #1;
    check("R1 pin_oe in reset", pin_oe, 8'h00);
    check("R1 pin_out in reset", pin_out, 8'h00);
    check("R1 pin_pull in reset", pin_pull, 8'h00);
    rst_n = 1'b1;
    check_pins("R1 after reset");
    rd(2'd1, 8'hFF, "R1 dir readback");
    rd(2'd2, 8'h00, "R1 pull readback");

    // R2 direction control
    wr(2'd1, 8'h0F);
    check_pins("R2 mixed dir");
    rd(2'd1, 8'h0F, "R2 dir readback");

    // R3 latch write and pin_out
    wr(2'd0, 8'hA5);
    check_pins("R3 latch write");

    // R4 / R5 mixed read: pins opposite of latch
    @(negedge clk); pin_in = 8'h5A;
    @(negedge clk); @(negedge clk);
    rd(2'd0, port_exp(8'h5A), "R4 R5 mixed read");

    // R4 synchronizer latency
    wr(2'd1, 8'hFF);
    @(negedge clk); pin_in = 8'h3C;
    rd(2'd0, 8'h5A, "R4 old level after one edge");
    rd(2'd0, 8'h3C, "R4 new level after two edges");

    // R5 all outputs, pin level ignored
    wr(2'd1, 8'h00);
    wr(2'd0, 8'hC3);
    @(negedge clk); pin_in = 8'h3C;
    repeat (3) @(negedge clk);
    rd(2'd0, 8'hC3, "R5 all outputs");
    pin_in = 8'hFF;
    repeat (3) @(negedge clk);
    rd(2'd0, 8'hC3, "R5 pin change ignored");

    // R6 pull-up
    wr(2'd2, 8'h96);
    check_pins("R6 pull write");
    rd(2'd2, 8'h96, "R6 pull readback");

    // R7 unused address
    rd(2'd3, 8'h00, "R7 unused read");
    @(negedge clk);
    bus_addr = 2'd3; bus_wr = 1'b1; bus_wdata = 8'h77;
    @(negedge clk); bus_wr = 1'b0;
    check_pins("R7 unused write no effect");
    rd(2'd1, m_dir, "R7 dir kept");
    rd(2'd2, m_pull, "R7 pull kept");

    // R8 bus activity without strobe
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      bus_addr = k[1:0]; bus_wr = 1'b0; bus_wdata = 8'hE1;
      @(negedge clk);
    end
    check_pins("R8 no strobe no effect");

    // mixed direction again, alternating split
    wr(2'd1, 8'hAA);
    wr(2'd0, 8'h0F);
    @(negedge clk); pin_in = 8'hF0;
    @(negedge clk); @(negedge clk);
    rd(2'd0, port_exp(8'hF0), "R4 R5 alternating split");
    check_pins("R2 alternating dir");

    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule